// File: doc/BRIEF.md
# Ethernet MAC Control and Status Register Block

This block is the host-visible register file of an Ethernet MAC. The registers are 32 bits wide and a host reaches them through a plain word-indexed read/write bus. The block holds the command word, the two descriptor-list base addresses, the maximum receive length, the interrupt enable and interrupt status words, and the current-descriptor pointers that the DMA engines report. It also keeps simple storage words for the management-interface data and address and for the FIFO threshold. Transmit and receive DMA engines raise events that set status bits. The block drives one interrupt line for the transmit half of the status word and a separate one for the receive half.

A write that sets command bit 24 starts a self-clearing software reset. This reset runs for a fixed, parameterised number of cycles. While it runs, every read returns zero and host writes have no effect. When it ends, every register holds its reset value. A write of any value to one of the two poll-demand indices sends a one-cycle kick to the matching DMA engine.

Top module: `mac_csr_block`

## Requirements
- R1: After `rst_n` is low at a clock edge, reads return these values: 0xFFFFFFFC at index 0x22 (transmit list base) and 0x23 (receive list base), 0x00900000 at 0x26 (management address), 0x00000101 at 0x27 (FIFO threshold), 0x00000800 at 0x2A (maximum receive length) and 0x00007FFF at 0x2E (missed-frame count). Every other index reads 0, and both interrupt lines are low.
- R2: At indices 0x22 and 0x23, bits 31:2 are writable and bits 1:0 always read 0. The values drive `tx_list_base` and `rx_list_base`.
- R3: Only command-word (index 0x24) bits 0 (receive on), 1 (long frames allowed) and 8 (transmit on) are stored. They drive `cfg_rx_on`, `cfg_long_ok` and `cfg_tx_on`. All other command bits read 0.
- R4: A write to index 0x24 with bit 24 set starts a software reset that lasts SWR_CYCLES cycles (default 8). From the edge that takes the write until SWR_CYCLES edges later, every read returns 0 and host writes and DMA events are ignored. After that, every register reads its R1 value.
- R5: A software reset clears the status word and both current-descriptor pointers. Both interrupt lines go low from the edge that takes the reset write.
- R6: A DMA event bit sets the status bit at index 0x2C at the next edge. Only these bits exist: 24 transmit bus error, 23 transmit descriptor unavailable, 18 transmit complete, 16 transmit interrupt, 11 receive bus error, 10 receive descriptor unavailable, 9 early DMA notice, 8 length overflow, 4 receive good, 3 frame too long, 0 receive interrupt. Event bits at any other position have no effect.
- R7: Writing a 1 to a status bit clears it. Writing a 0 leaves the bit unchanged.
- R8: If an event sets a status bit in the same cycle as a host write that clears it, the bit ends up set.
- R9: Only enable-word (index 0x2B) bits 18, 16, 4 and 0 are stored. `tx_irq` is high exactly when a status bit in bits 31:16 and its enable bit are both 1.
- R10: `rx_irq` is high exactly when a status bit in bits 15:0 and its enable bit are both 1.
- R11: A write of any value to index 0x28 or 0x29 drives `tx_poll_kick` or `rx_poll_kick` high for exactly the one cycle after the edge that takes the write.
- R12: A load strobe from a DMA engine stores that engine's pointer. The transmit pointer reads at index 0x33 and the receive pointer at index 0x35. Host writes to these indices are ignored.
- R13: Indices 0x25, 0x26, 0x27 and 0x2A read back what was written. The low 16 bits of index 0x2A drive `rx_len_limit`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Write strobe for the addressed register |
| host_addr | input | ADDR_W | Register index (byte address divided by 4) |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for `host_addr`, combinational |
| evt_set | input | 32 | Status-set events from the DMA engines |
| txd_ptr_ld | input | 1 | Load strobe for the transmit current-descriptor pointer |
| txd_ptr_val | input | 32 | New transmit pointer value |
| rxd_ptr_ld | input | 1 | Load strobe for the receive current-descriptor pointer |
| rxd_ptr_val | input | 32 | New receive pointer value |
| tx_list_base | output | 32 | Transmit descriptor list base |
| rx_list_base | output | 32 | Receive descriptor list base |
| rx_len_limit | output | 16 | Maximum receive length |
| cfg_tx_on | output | 1 | Transmit enabled |
| cfg_rx_on | output | 1 | Receive enabled |
| cfg_long_ok | output | 1 | Long frames accepted |
| tx_poll_kick | output | 1 | One-cycle transmit poll demand |
| rx_poll_kick | output | 1 | One-cycle receive poll demand |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Two functions can land on one edge: a DMA event that sets a status bit, and a host write-one that clears the same bit. The bench drives both in one cycle on receive-good and expects the bit to read back set. A second collision happens when the software reset starts while status bits and interrupts are active. A write during the reset window and an event during that window must both leave no trace, which the bench confirms by reading the registers once the window closes.

// File: rtl/mac_csr_pkg.sv
// Package: register indices, field positions, implemented-bit masks and
// reset values shared by the MAC control/status block and its bench.
// Assumes word indices fit in 6 bits.
package mac_csr_pkg;
    localparam int unsigned DW = 32;

    // Word indices (neighbouring logic decodes these offsets)
    localparam int unsigned IX_TXLIST  = 'h22;
    localparam int unsigned IX_RXLIST  = 'h23;
    localparam int unsigned IX_CMD     = 'h24;
    localparam int unsigned IX_MIIDATA = 'h25;
    localparam int unsigned IX_MIIADDR = 'h26;
    localparam int unsigned IX_FIFOTH  = 'h27;
    localparam int unsigned IX_TXPOLL  = 'h28;
    localparam int unsigned IX_RXPOLL  = 'h29;
    localparam int unsigned IX_MAXRX   = 'h2A;
    localparam int unsigned IX_IEN     = 'h2B;
    localparam int unsigned IX_ISTS    = 'h2C;
    localparam int unsigned IX_MISS    = 'h2E;
    localparam int unsigned IX_CURTXD  = 'h33;
    localparam int unsigned IX_CURRXD  = 'h35;

    // Command word fields
    localparam int unsigned CMD_RXON = 0;
    localparam int unsigned CMD_LONG = 1;
    localparam int unsigned CMD_TXON = 8;
    localparam int unsigned CMD_SWR  = 24;

    // Implemented status and enable bits
    localparam logic [DW-1:0] STS_MASK = 32'h0185_0F19;
    localparam logic [DW-1:0] IEN_MASK = 32'h0005_0011;

    // Reset values
    localparam logic [DW-1:0] RST_LIST    = 32'hFFFF_FFFC;
    localparam logic [DW-1:0] RST_MIIADDR = 32'h0090_0000;
    localparam logic [DW-1:0] RST_FIFOTH  = 32'h0000_0101;
    localparam logic [15:0]   RST_MAXRX   = 16'h0800;
    localparam logic [DW-1:0] RST_MISS    = 32'h0000_7FFF;

    // Number of DMA channels (transmit, receive)
    localparam int unsigned NCH = 2;
endpackage

// File: rtl/mac_csr_swrst.sv
// Software reset sequencer: a start pulse holds busy high for CYCLES
// clock cycles, then busy drops by itself.
// Assumes start is only raised while busy is low.
module mac_csr_swrst #(
    parameter int unsigned CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    // Load the window length on start, count down, release at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= CW'(CYCLES - 1);
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end

    // R4
    swr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/mac_csr_isr.sv
// Interrupt enable/status pair with write-one-to-clear status, event set
// priority over clear, and the split transmit/receive interrupt lines.
// Assumes busy marks a software reset window, during which all state is
// held at reset and the lines are forced low.
module mac_csr_isr
    import mac_csr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          ien_we,
    input  logic          sts_we,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] evt_set,
    output logic [DW-1:0] ien,
    output logic [DW-1:0] sts,
    output logic          tx_irq,
    output logic          rx_irq
);
    localparam int unsigned HW = DW / 2;

    logic [DW-1:0] clr_vec;
    logic [DW-1:0] hit;

    // Clear vector from a host write-one to the status word
    always_comb clr_vec = sts_we ? wdata : '0;

    // Enable and status registers; set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n || busy) begin
            ien <= '0;
            sts <= '0;
        end else begin
            if (ien_we) ien <= wdata & IEN_MASK;
            sts <= (sts & ~clr_vec) | (evt_set & STS_MASK);
        end
    end

    // Split masked status into the two interrupt lines
    always_comb begin
        hit    = sts & ien;
        tx_irq = !busy && (|hit[DW-1:HW]);
        rx_irq = !busy && (|hit[HW-1:0]);
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ((evt_set & STS_MASK) != '0)) |=>
        ((sts & $past(evt_set & STS_MASK)) == $past(evt_set & STS_MASK)));

    // R7
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sts_we && ((evt_set & STS_MASK) == '0)) |=>
        ((sts & $past(wdata)) == '0));

    // R5
    swr_clears_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (sts == '0));
endmodule

// File: rtl/mac_csr_block.sv
// MAC control/status register block: word-indexed host register file,
// descriptor base and pointer registers, poll-demand kicks, interrupt
// status with split interrupt lines, and the self-clearing software reset.
// Assumes a single-cycle host write strobe and combinational read data.
module mac_csr_block
    import mac_csr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 6,
    parameter int unsigned SWR_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    input  logic [DW-1:0]     evt_set,
    input  logic              txd_ptr_ld,
    input  logic [DW-1:0]     txd_ptr_val,
    input  logic              rxd_ptr_ld,
    input  logic [DW-1:0]     rxd_ptr_val,
    output logic [DW-1:0]     tx_list_base,
    output logic [DW-1:0]     rx_list_base,
    output logic [15:0]       rx_len_limit,
    output logic              cfg_tx_on,
    output logic              cfg_rx_on,
    output logic              cfg_long_ok,
    output logic              tx_poll_kick,
    output logic              rx_poll_kick,
    output logic              tx_irq,
    output logic              rx_irq
);
    logic          busy;
    logic          wr_ok;
    logic          swr_start;
    logic [DW-1:0] ien_q;
    logic [DW-1:0] sts_q;
    logic [DW-1:0] list_base [NCH];
    logic [DW-1:0] cur_ptr   [NCH];
    logic [NCH-1:0] ptr_ld;
    logic [DW-1:0] ptr_val   [NCH];
    logic [NCH-1:0] kick;
    logic [2:0]    cmd_q;
    logic [DW-1:0] miidata_q, miiaddr_q, fifoth_q;
    logic [15:0]   maxrx_q;

    // Host writes take effect only outside the reset window
    always_comb begin
        wr_ok     = host_wr && !busy;
        swr_start = wr_ok && (host_addr == ADDR_W'(IX_CMD)) && host_wdata[CMD_SWR];
    end

    mac_csr_swrst #(.CYCLES(SWR_CYCLES)) u_swrst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (swr_start),
        .busy  (busy)
    );

    mac_csr_isr u_isr (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .ien_we  (wr_ok && (host_addr == ADDR_W'(IX_IEN))),
        .sts_we  (wr_ok && (host_addr == ADDR_W'(IX_ISTS))),
        .wdata   (host_wdata),
        .evt_set (evt_set),
        .ien     (ien_q),
        .sts     (sts_q),
        .tx_irq  (tx_irq),
        .rx_irq  (rx_irq)
    );

    // Gather the per-channel DMA pointer inputs
    always_comb begin
        ptr_ld     = {rxd_ptr_ld, txd_ptr_ld};
        ptr_val[0] = txd_ptr_val;
        ptr_val[1] = rxd_ptr_val;
    end

    // Per-channel list base, current pointer and poll kick
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        localparam int unsigned IX_BASE = IX_TXLIST + c;
        localparam int unsigned IX_POLL = IX_TXPOLL + c;

        // Word-aligned list base, host writable
        always_ff @(posedge clk) begin
            if (!rst_n || busy)
                list_base[c] <= RST_LIST;
            else if (wr_ok && (host_addr == ADDR_W'(IX_BASE)))
                list_base[c] <= {host_wdata[DW-1:2], 2'b00};
        end

        // Current descriptor pointer, loaded only by the DMA engine
        always_ff @(posedge clk) begin
            if (!rst_n || busy)  cur_ptr[c] <= '0;
            else if (ptr_ld[c])  cur_ptr[c] <= ptr_val[c];
        end

        // One-cycle poll demand on any write to the poll index
        always_ff @(posedge clk) begin
            if (!rst_n) kick[c] <= 1'b0;
            else        kick[c] <= wr_ok && (host_addr == ADDR_W'(IX_POLL));
        end
    end

    // Command bits and plain configuration storage
    always_ff @(posedge clk) begin
        if (!rst_n || busy) begin
            cmd_q     <= '0;
            miidata_q <= '0;
            miiaddr_q <= RST_MIIADDR;
            fifoth_q  <= RST_FIFOTH;
            maxrx_q   <= RST_MAXRX;
        end else if (wr_ok) begin
            case (int'(host_addr))
                IX_CMD:     cmd_q <= {host_wdata[CMD_TXON], host_wdata[CMD_LONG],
                                      host_wdata[CMD_RXON]};
                IX_MIIDATA: miidata_q <= host_wdata;
                IX_MIIADDR: miiaddr_q <= host_wdata;
                IX_FIFOTH:  fifoth_q  <= host_wdata;
                IX_MAXRX:   maxrx_q   <= host_wdata[15:0];
                default: ;
            endcase
        end
    end

    // Read mux; everything reads zero during the reset window
    always_comb begin
        host_rdata = '0;
        if (!busy) begin
            case (int'(host_addr))
                IX_TXLIST:  host_rdata = list_base[0];
                IX_RXLIST:  host_rdata = list_base[1];
                IX_CMD: begin
                    host_rdata[CMD_RXON] = cmd_q[0];
                    host_rdata[CMD_LONG] = cmd_q[1];
                    host_rdata[CMD_TXON] = cmd_q[2];
                end
                IX_MIIDATA: host_rdata = miidata_q;
                IX_MIIADDR: host_rdata = miiaddr_q;
                IX_FIFOTH:  host_rdata = fifoth_q;
                IX_MAXRX:   host_rdata = {16'h0, maxrx_q};
                IX_IEN:     host_rdata = ien_q;
                IX_ISTS:    host_rdata = sts_q;
                IX_MISS:    host_rdata = RST_MISS;
                IX_CURTXD:  host_rdata = cur_ptr[0];
                IX_CURRXD:  host_rdata = cur_ptr[1];
                default:    host_rdata = '0;
            endcase
        end
    end

    // Drive configuration outputs
    always_comb begin
        tx_list_base = list_base[0];
        rx_list_base = list_base[1];
        rx_len_limit = maxrx_q;
        cfg_rx_on    = cmd_q[0];
        cfg_long_ok  = cmd_q[1];
        cfg_tx_on    = cmd_q[2];
        tx_poll_kick = kick[0];
        rx_poll_kick = kick[1];
    end

    // R4
    swr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (host_rdata == '0));

    // R11
    tx_kick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_poll_kick |-> $past(host_wr && (host_addr == ADDR_W'(IX_TXPOLL))));

    // R12
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !txd_ptr_ld) |=> $stable(cur_ptr[0]));
endmodule

// File: tb/mac_csr_block_tb.sv
// Scoreboard bench: driver tasks push expected observations into a queue;
// a monitor pops them a few ns after the next rising edge and compares.
module mac_csr_block_tb;
    import mac_csr_pkg::*;

    localparam int unsigned AW  = 6;
    localparam int unsigned NSW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0]   host_wdata = '0;
    logic [31:0]   host_rdata;
    logic [31:0]   evt_set = '0;
    logic          txd_ptr_ld = 1'b0, rxd_ptr_ld = 1'b0;
    logic [31:0]   txd_ptr_val = '0, rxd_ptr_val = '0;
    logic [31:0]   tx_list_base, rx_list_base;
    logic [15:0]   rx_len_limit;
    logic          cfg_tx_on, cfg_rx_on, cfg_long_ok;
    logic          tx_poll_kick, rx_poll_kick, tx_irq, rx_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    mac_csr_block #(.ADDR_W(AW), .SWR_CYCLES(NSW)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .evt_set(evt_set),
        .txd_ptr_ld(txd_ptr_ld), .txd_ptr_val(txd_ptr_val),
        .rxd_ptr_ld(rxd_ptr_ld), .rxd_ptr_val(rxd_ptr_val),
        .tx_list_base(tx_list_base), .rx_list_base(rx_list_base),
        .rx_len_limit(rx_len_limit), .cfg_tx_on(cfg_tx_on),
        .cfg_rx_on(cfg_rx_on), .cfg_long_ok(cfg_long_ok),
        .tx_poll_kick(tx_poll_kick), .rx_poll_kick(rx_poll_kick),
        .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    // kind: 0 read data, 1 tx_irq, 2 rx_irq, 3 tx kick, 4 rx kick,
    // 5 {long, rx_on, tx_on}, 6 tx_list_base, 7 rx_len_limit
    task automatic expect_obs(int k, logic [31:0] e, string t);
        sb.push_back('{k, e, t});
    endtask

    // Monitor: compare every queued item after the next rising edge
    initial begin
        forever begin
            @(posedge clk);
            #3;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0: act = host_rdata;
                    1: act = {31'b0, tx_irq};
                    2: act = {31'b0, rx_irq};
                    3: act = {31'b0, tx_poll_kick};
                    4: act = {31'b0, rx_poll_kick};
                    5: act = {29'b0, cfg_long_ok, cfg_rx_on, cfg_tx_on};
                    6: act = tx_list_base;
                    default: act = {16'b0, rx_len_limit};
                endcase
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h",
                             it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic wr(int a, logic [31:0] d);
        host_wr = 1'b1; host_addr = AW'(a); host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(int a, logic [31:0] e, string t);
        host_addr = AW'(a);
        expect_obs(0, e, t);
        @(negedge clk);
    endtask

    task automatic ev(logic [31:0] v);
        evt_set = v; host_addr = AW'(IX_ISTS);
        @(negedge clk);
        evt_set = '0;
    endtask

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd(IX_TXLIST,  32'hFFFF_FFFC, "R1 txlist");
        rd(IX_RXLIST,  32'hFFFF_FFFC, "R1 rxlist");
        rd(IX_MIIADDR, 32'h0090_0000, "R1 miiaddr");
        rd(IX_FIFOTH,  32'h0000_0101, "R1 fifoth");
        rd(IX_MAXRX,   32'h0000_0800, "R1 maxrx");
        rd(IX_MISS,    32'h0000_7FFF, "R1 miss");
        rd(IX_CMD,     32'h0, "R1 cmd");
        rd(IX_ISTS,    32'h0, "R1 sts");
        expect_obs(1, 0, "R1 txirq"); expect_obs(2, 0, "R1 rxirq");
        rd(IX_CURTXD,  32'h0, "R1 curtx");

        // R2 list base alignment
        wr(IX_TXLIST, 32'h1234_5677);
        expect_obs(6, 32'h1234_5674, "R2 txbase out");
        rd(IX_TXLIST, 32'h1234_5674, "R2 txlist");
        wr(IX_RXLIST, 32'hABCD_EF03);
        rd(IX_RXLIST, 32'hABCD_EF00, "R2 rxlist");

        // R3 command bits
        wr(IX_CMD, 32'h00FF_FFFF);
        expect_obs(5, 32'h7, "R3 cfg outs");
        rd(IX_CMD, 32'h0000_0103, "R3 cmd");
        wr(IX_CMD, 32'h0000_0100);
        expect_obs(5, 32'h1, "R3 txon only");
        rd(IX_CMD, 32'h0000_0100, "R3 cmd tx");

        // R13 storage registers
        wr(IX_MAXRX, 32'h0000_1234);
        expect_obs(7, 32'h1234, "R13 len out");
        rd(IX_MAXRX, 32'h0000_1234, "R13 maxrx");
        wr(IX_MIIDATA, 32'hDEAD_BEEF);
        rd(IX_MIIDATA, 32'hDEAD_BEEF, "R13 miidata");
        wr(IX_FIFOTH, 32'h0000_0303);
        rd(IX_FIFOTH, 32'h0000_0303, "R13 fifoth");

        // R9 enable mask
        wr(IX_IEN, 32'hFFFF_FFFF);
        rd(IX_IEN, 32'h0005_0011, "R9 ien");

        // R6 all events, only defined bits
        expect_obs(0, 32'h0185_0F19, "R6 all events");
        ev(32'hFFFF_FFFF);
        wr(IX_ISTS, 32'hFFFF_FFFF);
        rd(IX_ISTS, 32'h0, "R7 clear all");

        // R9 unenabled status does not raise tx_irq
        expect_obs(0, 32'h0080_0000, "R9 tdu set");
        expect_obs(1, 0, "R9 tdu no irq");
        ev(32'h0080_0000);
        expect_obs(1, 1, "R9 txcp irq");
        expect_obs(2, 0, "R10 rx quiet");
        ev(32'h0004_0000);
        // R7 write one clears, zero leaves
        wr(IX_ISTS, 32'h0004_0000);
        expect_obs(1, 0, "R7 tx irq drop");
        rd(IX_ISTS, 32'h0080_0000, "R7 w1c");
        wr(IX_ISTS, 32'h0);
        rd(IX_ISTS, 32'h0080_0000, "R7 write0");

        // R10 receive line; R6 undefined bit 5 ignored
        expect_obs(2, 1, "R10 rx irq");
        expect_obs(1, 0, "R10 tx quiet");
        expect_obs(0, 32'h0080_0010, "R6 bit5 ignored");
        ev(32'h0000_0030);

        // R8 set wins over clear in the same cycle
        host_wr = 1'b1; host_addr = AW'(IX_ISTS); host_wdata = 32'h0080_0010;
        evt_set = 32'h0000_0010;
        expect_obs(0, 32'h0000_0010, "R8 set wins");
        @(negedge clk);
        host_wr = 1'b0; evt_set = '0;
        expect_obs(2, 1, "R8 rx irq kept");
        rd(IX_ISTS, 32'h0000_0010, "R8 hold");

        // R12 DMA pointers
        txd_ptr_ld = 1'b1; txd_ptr_val = 32'hA000_0010;
        rxd_ptr_ld = 1'b1; rxd_ptr_val = 32'hB000_0020;
        @(negedge clk);
        txd_ptr_ld = 1'b0; rxd_ptr_ld = 1'b0;
        wr(IX_CURTXD, 32'h5);
        rd(IX_CURTXD, 32'hA000_0010, "R12 curtx");
        rd(IX_CURRXD, 32'hB000_0020, "R12 currx");

        // R11 poll kicks
        expect_obs(3, 1, "R11 tx kick");
        expect_obs(4, 0, "R11 rx idle");
        wr(IX_TXPOLL, 32'h0);
        expect_obs(3, 0, "R11 tx kick one cycle");
        expect_obs(4, 1, "R11 rx kick");
        wr(IX_RXPOLL, 32'h1234);
        expect_obs(4, 0, "R11 rx kick one cycle");
        @(negedge clk);

        // R4/R5 software reset with irqs active
        ev(32'h0001_0000);
        expect_obs(1, 1, "R5 tx irq before");
        rd(IX_ISTS, 32'h0001_0010, "R5 sts before");
        host_wr = 1'b1; host_addr = AW'(IX_FIFOTH);
        host_addr = AW'(IX_CMD); host_wdata = 32'h0100_0103;
        expect_obs(0, 0, "R4 read zero 0");
        expect_obs(1, 0, "R5 tx irq low");
        expect_obs(2, 0, "R5 rx irq low");
        @(negedge clk);
        host_wr = 1'b0;
        for (int i = 1; i < int'(NSW); i++) begin
            if (i == 2) begin
                host_wr = 1'b1; host_addr = AW'(IX_TXLIST); host_wdata = 32'h0;
            end else if (i == 3) begin
                evt_set = 32'h0000_0001; host_addr = AW'(IX_FIFOTH);
            end else begin
                host_addr = AW'(IX_FIFOTH);
            end
            expect_obs(0, 0, "R4 read zero");
            @(negedge clk);
            host_wr = 1'b0; evt_set = '0;
        end
        rd(IX_FIFOTH, 32'h0000_0101, "R4 fifoth restored");
        rd(IX_TXLIST, 32'hFFFF_FFFC, "R4 write ignored");
        rd(IX_CMD,    32'h0, "R4 cmd cleared");
        rd(IX_IEN,    32'h0, "R4 ien cleared");
        rd(IX_ISTS,   32'h0, "R5 sts cleared");
        rd(IX_CURTXD, 32'h0, "R5 curtx cleared");
        expect_obs(5, 0, "R4 cfg outs");
        rd(IX_MAXRX,  32'h0000_0800, "R4 maxrx restored");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule